// File: doc/BRIEF.md
# Precise Exception Control Unit

This block sits beside a five-stage in-order pipeline and turns two fault flags into a precise trap. The decode stage reports an undefined opcode together with its instruction address. The execute stage reports an arithmetic overflow together with its instruction address. When a fault is accepted, the unit does four things in the same cycle:

- It asserts flush strobes, and the pipeline uses them to zero the control fields of the faulting instruction and of every younger one. The same mechanism serves a mispredicted branch.
- For an overflow, it kills the register write of the faulting instruction.
- It redirects fetch to a handler entry address for exactly one cycle.
- It records a one-bit cause and an exception return address, which appear on the read ports from the next cycle.

Instructions older than the faulting one are never flushed and retire normally.

When both stages fault in the same cycle, the execute-stage instruction is the older one and wins. After an accepted fault, the unit ignores further fault flags for a fixed number of drain cycles, while the flushed stages empty. A return-from-handler strobe redirects fetch to the saved return address and ends the drain window at once. A parameter chooses between two handler entry schemes: a single fixed entry, or an entry per cause taken from a vector table.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, the cause read port is 0, the return-address read port is 0, and pc_load and all flush strobes are 0.
- R2: An accepted overflow (ex_ovf=1) asserts flush_if, flush_id and flush_ex in the same cycle. flush_ex is the strobe that zeroes the execute-stage instruction's control, including its register write.
- R3: An accepted undefined opcode (id_undef=1 with ex_ovf=0) asserts flush_if and flush_id in the same cycle and leaves flush_ex at 0, so the older execute-stage instruction completes.
- R4: When ex_ovf and id_undef are both high in one cycle, the overflow is taken: cause becomes 1 and the return address is derived from ex_pc.
- R5: The cause encoding is 0 for an undefined opcode and 1 for an overflow. It is visible on cause_q from the cycle after acceptance.
- R6: From the cycle after acceptance, epc_q holds the faulting instruction's address plus 4, modulo 2^XLEN.
- R7: With VECTORED=0, the redirect target for any fault is 0x80000180.
- R8: With VECTORED=1, the redirect target is 0xC0000000 + 0x20 * cause: 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow.
- R9: pc_load is high for exactly one cycle per accepted fault, even when the fault flag stays high.
- R10: For DRAIN_CYCLES cycles after an acceptance, fault flags are ignored: no flush, no redirect, and cause_q and epc_q stay unchanged.
- R11: ret_req asserts pc_load with pc_target equal to epc_q in the same cycle, and it ends the drain window, so a fault in the next cycle is accepted.
- R12: When a fault is accepted in the same cycle as ret_req, the fault wins and the target is the handler entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_undef | input | 1 | Decode stage holds an undefined opcode |
| id_pc | input | XLEN | Address of the decode-stage instruction |
| ex_ovf | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc | input | XLEN | Address of the execute-stage instruction |
| ret_req | input | 1 | Return from handler |
| flush_if | output | 1 | Zero the fetch-stage instruction |
| flush_id | output | 1 | Zero the control of the decode-stage instruction |
| flush_ex | output | 1 | Zero the control of the execute-stage instruction, including its register write |
| pc_load | output | 1 | Override the next fetch address this cycle |
| pc_target | output | XLEN | Fetch address used when pc_load is high |
| cause_q | output | 1 | Saved cause (0 undefined opcode, 1 overflow) |
| epc_q | output | XLEN | Saved return address |

## Verification
The bench builds two copies side by side: one with VECTORED=0 and one with VECTORED=1, both with XLEN=32 and DRAIN_CYCLES=3. Driving the same stimulus into both lets every fault check the fixed entry and both vector slots at once. The short three-cycle drain window lets the bench walk a held fault flag through its whole blocked interval and see it accepted again. The 32-bit width brings the wrap of the return address past 0xFFFFFFFC within reach.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic {
        CAUSE_UNDEF = 1'b0,
        CAUSE_OVF   = 1'b1
    } exc_cause_e;

    localparam logic [31:0] FIXED_ENTRY = 32'h8000_0180;
    localparam logic [31:0] VEC_BASE    = 32'hC000_0000;
    localparam logic [31:0] VEC_STRIDE  = 32'h0000_0020;
    localparam logic [31:0] RET_OFFSET  = 32'h0000_0004;

    function automatic logic [31:0] vector_entry(input exc_cause_e c);
        return VEC_BASE + VEC_STRIDE * 32'(c);
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            enable,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    output logic            take,
    output exc_cause_e      cause,
    output logic [XLEN-1:0] fault_pc,
    output logic            kill_if,
    output logic            kill_id,
    output logic            kill_ex
);
    // Execute holds the older instruction, so its fault is chosen first.
    always_comb begin
        take     = 1'b0;
        cause    = CAUSE_UNDEF;
        fault_pc = id_pc;
        kill_if  = 1'b0;
        kill_id  = 1'b0;
        kill_ex  = 1'b0;
        if (enable) begin
            if (ex_ovf) begin
                take     = 1'b1;
                cause    = CAUSE_OVF;
                fault_pc = ex_pc;
                kill_if  = 1'b1;
                kill_id  = 1'b1;
                kill_ex  = 1'b1;
            end else if (id_undef) begin
                take     = 1'b1;
                cause    = CAUSE_UNDEF;
                fault_pc = id_pc;
                kill_if  = 1'b1;
                kill_id  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_vec.sv
module exc_vec
    import exc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit VECTORED = 1'b0
) (
    input  exc_cause_e      cause,
    output logic [XLEN-1:0] entry
);
    generate
        if (VECTORED) begin : g_vectored
            assign entry = XLEN'(vector_entry(cause));
        end else begin : g_fixed
            logic cause_unused;
            assign cause_unused = cause;
            assign entry = XLEN'(FIXED_ENTRY);
        end
    endgenerate
endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int DRAIN_CYCLES = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  exc_cause_e      cause,
    input  logic [XLEN-1:0] fault_pc,
    input  logic            ret_req,
    output exc_cause_e      cause_q,
    output logic [XLEN-1:0] epc_q,
    output logic            busy
);
    localparam int CW = $clog2(DRAIN_CYCLES + 1);

    logic [CW-1:0] drain_cnt;

    assign busy = (drain_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q   <= CAUSE_UNDEF;
            epc_q     <= '0;
            drain_cnt <= '0;
        end else if (take) begin
            cause_q   <= cause;
            epc_q     <= fault_pc + XLEN'(RET_OFFSET);
            drain_cnt <= CW'(DRAIN_CYCLES);
        end else if (ret_req) begin
            drain_cnt <= '0;
        end else if (busy) begin
            drain_cnt <= drain_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter bit VECTORED     = 1'b0,
    parameter int DRAIN_CYCLES = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            ret_req,
    output logic            flush_if,
    output logic            flush_id,
    output logic            flush_ex,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target,
    output logic            cause_q,
    output logic [XLEN-1:0] epc_q
);
    logic            take;
    logic            busy;
    exc_cause_e      sel_cause;
    exc_cause_e      saved_cause;
    logic [XLEN-1:0] sel_pc;
    logic [XLEN-1:0] entry;

    exc_prio #(.XLEN(XLEN)) u_prio (
        .enable   (!busy),
        .id_undef (id_undef),
        .id_pc    (id_pc),
        .ex_ovf   (ex_ovf),
        .ex_pc    (ex_pc),
        .take     (take),
        .cause    (sel_cause),
        .fault_pc (sel_pc),
        .kill_if  (flush_if),
        .kill_id  (flush_id),
        .kill_ex  (flush_ex)
    );

    exc_vec #(.XLEN(XLEN), .VECTORED(VECTORED)) u_vec (
        .cause (sel_cause),
        .entry (entry)
    );

    exc_state #(.XLEN(XLEN), .DRAIN_CYCLES(DRAIN_CYCLES)) u_state (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .cause    (sel_cause),
        .fault_pc (sel_pc),
        .ret_req  (ret_req),
        .cause_q  (saved_cause),
        .epc_q    (epc_q),
        .busy     (busy)
    );

    assign cause_q   = saved_cause;
    assign pc_load   = take | ret_req;
    assign pc_target = take ? entry : epc_q;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            id_undef,
    input logic [XLEN-1:0] id_pc,
    input logic            ex_ovf,
    input logic [XLEN-1:0] ex_pc,
    input logic            ret_req,
    input logic            flush_if,
    input logic            flush_id,
    input logic            flush_ex,
    input logic            pc_load,
    input logic [XLEN-1:0] pc_target,
    input logic            cause_q,
    input logic [XLEN-1:0] epc_q
);
    p_kill_write_r2: assert property (@(posedge clk) disable iff (rst)
        (flush_id && ex_ovf) |-> (flush_ex && flush_if && pc_load));

    p_older_survives_r3: assert property (@(posedge clk) disable iff (rst)
        (flush_id && !ex_ovf) |-> (!flush_ex && id_undef));

    p_cause_code_r5: assert property (@(posedge clk) disable iff (rst)
        flush_id |=> (cause_q == $past(ex_ovf)));

    p_epc_plus4_r6: assert property (@(posedge clk) disable iff (rst)
        flush_id |=> (epc_q == ($past(ex_ovf ? ex_pc : id_pc) + XLEN'(4))));

    p_one_cycle_load_r9: assert property (@(posedge clk) disable iff (rst)
        flush_id |=> (!pc_load || ret_req));

    p_drain_block_r10: assert property (@(posedge clk) disable iff (rst)
        flush_id |=> !flush_id);

    p_ret_target_r11: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !flush_id) |-> (pc_load && pc_target == epc_q));

    p_flush_nested_r2: assert property (@(posedge clk) disable iff (rst)
        flush_ex |-> (flush_id && flush_if));
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            id_undef = 1'b0;
    logic [XLEN-1:0] id_pc = '0;
    logic            ex_ovf = 1'b0;
    logic [XLEN-1:0] ex_pc = '0;
    logic            ret_req = 1'b0;

    logic            f_fif, f_fid, f_fex, f_load, f_cause;
    logic [XLEN-1:0] f_tgt, f_epc;
    logic            v_fif, v_fid, v_fex, v_load, v_cause;
    logic [XLEN-1:0] v_tgt, v_epc;

    int total = 0;
    int failed = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    exc_ctrl #(.XLEN(XLEN), .VECTORED(1'b0), .DRAIN_CYCLES(3)) i_exc_ctrl (
        .clk(clk), .rst(rst), .id_undef(id_undef), .id_pc(id_pc),
        .ex_ovf(ex_ovf), .ex_pc(ex_pc), .ret_req(ret_req),
        .flush_if(f_fif), .flush_id(f_fid), .flush_ex(f_fex),
        .pc_load(f_load), .pc_target(f_tgt), .cause_q(f_cause), .epc_q(f_epc)
    );

    exc_ctrl #(.XLEN(XLEN), .VECTORED(1'b1), .DRAIN_CYCLES(3)) i_exc_ctrl_vec (
        .clk(clk), .rst(rst), .id_undef(id_undef), .id_pc(id_pc),
        .ex_ovf(ex_ovf), .ex_pc(ex_pc), .ret_req(ret_req),
        .flush_if(v_fif), .flush_id(v_fid), .flush_ex(v_fex),
        .pc_load(v_load), .pc_target(v_tgt), .cause_q(v_cause), .epc_q(v_epc)
    );

    // {ex_ovf, id_undef, ex_pc, id_pc, expected epc}
    localparam logic [97:0] VECS [5] = '{
        {1'b1, 1'b0, 32'h0000_0100, 32'h0000_0104, 32'h0000_0104},
        {1'b0, 1'b1, 32'h0000_0200, 32'h0000_2000, 32'h0000_2004},
        {1'b1, 1'b1, 32'h0000_0300, 32'h0000_0304, 32'h0000_0304},
        {1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFC, 32'h0000_0000},
        {1'b1, 1'b0, 32'h7FFF_FFF0, 32'h1234_5678, 32'h7FFF_FFF4}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        id_undef = 1'b0;
        ex_ovf   = 1'b0;
        ret_req  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        logic o, u;
        logic [31:0] xp, dp, ee;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cause", 32'(f_cause), 32'h0);
        chk("R1 epc", f_epc, 32'h0);
        chk("R1 pc_load", 32'(f_load), 32'h0);
        chk("R1 flushes", {29'h0, f_fif, f_fid, f_fex}, 32'h0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 5; i++) begin
            {o, u, xp, dp, ee} = VECS[i];
            ex_ovf = o; id_undef = u; ex_pc = xp; id_pc = dp;
            #1;
            chk("R2 flush_if", 32'(f_fif), 32'h1);
            chk("R2/R3 flush_id", 32'(f_fid), 32'h1);
            chk("R2/R3 flush_ex", 32'(f_fex), 32'(o));
            chk("R9 pc_load", 32'(f_load), 32'h1);
            chk("R7 fixed entry", f_tgt, 32'h8000_0180);
            chk("R8 vector entry", v_tgt, o ? 32'hC000_0020 : 32'hC000_0000);
            @(negedge clk);
            idle_inputs();
            chk("R4/R5 cause", 32'(f_cause), 32'(o));
            chk("R6 epc", f_epc, ee);
            chk("R5 vec cause", 32'(v_cause), 32'(o));
            repeat (3) @(negedge clk);
        end

        // R9 and R10: held overflow, then a decode fault inside the drain window
        ex_ovf = 1'b1; ex_pc = 32'h40;
        #1;
        chk("R9 first load", 32'(f_load), 32'h1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (k == 1) begin
                ex_ovf = 1'b0; id_undef = 1'b1; id_pc = 32'h900;
            end
            #1;
            chk("R9 load held flag", 32'(f_load), 32'h0);
            chk("R10 no flush", 32'(f_fid), 32'h0);
        end
        idle_inputs();
        @(negedge clk);
        chk("R10 epc kept", f_epc, 32'h44);
        chk("R10 cause kept", 32'(f_cause), 32'h1);

        // R11 return ends drain
        id_undef = 1'b1; id_pc = 32'h500;
        @(negedge clk);
        idle_inputs();
        chk("R11 epc saved", f_epc, 32'h504);
        ret_req = 1'b1;
        #1;
        chk("R11 ret load", 32'(f_load), 32'h1);
        chk("R11 ret target", f_tgt, 32'h504);
        chk("R11 no flush", 32'(f_fid), 32'h0);
        @(negedge clk);
        ret_req = 1'b0; ex_ovf = 1'b1; ex_pc = 32'h600;
        #1;
        chk("R11 accepted after ret", 32'(f_fex), 32'h1);
        @(negedge clk);
        idle_inputs();
        chk("R11 epc", f_epc, 32'h604);
        repeat (3) @(negedge clk);

        // R12 fault beats return
        ret_req = 1'b1; ex_ovf = 1'b1; ex_pc = 32'h700;
        #1;
        chk("R12 fixed target", f_tgt, 32'h8000_0180);
        chk("R12 vector target", v_tgt, 32'hC000_0020);
        @(negedge clk);
        idle_inputs();
        chk("R12 epc", f_epc, 32'h704);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule